// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block watches the seconds, minutes and hours bytes of a real-time clock and compares them with three programmable alarm bytes. Each time the clock finishes a one-second update, it gives a strobe. On that strobe the block compares the bytes once, after the new time has settled. When every field matches, it sends a single-cycle pulse toward the alarm flag. The pulse always sets that flag. Whether the flag then raises an interrupt is decided outside this block.

An alarm byte whose most significant bit is set is a wildcard and matches any value of its field. With this, one comparator serves a daily alarm, an hourly alarm (hours wild), an alarm once a minute (hours and minutes wild) or an alarm every second (all three wild). The bytes are compared as raw bits, whatever number format the clock uses. No pulse is made while the clock's set control holds updates off.

Top module: `alarm_match`

## Requirements
- R1: While reset is asserted, `alarm_hit` is low, and it stays low after reset until a strobe produces a match.
- R2: If all three alarm bytes equal their time bytes bit for bit when `upd_done` rises, `alarm_hit` is high for exactly the one cycle that follows that edge.
- R3: If any alarm byte with its MSB (bit W-1) clear differs from its time byte when `upd_done` rises, no pulse is produced.
- R4: An alarm byte with bit W-1 set matches every value of its time field, including time values that have bit W-1 set.
- R5: With all three alarm bytes wild, every rising edge of `upd_done` (with `set_hold` low) produces one pulse.
- R6: `alarm_hit` is never high except in the cycle that follows a rising edge of `upd_done`, whatever the comparison gives in other cycles.
- R7: If `upd_done` stays high for several cycles, at most one pulse is produced, one cycle wide.
- R8: When `set_hold` is high in the cycle where `upd_done` rises, no pulse is produced even if all fields match.
- R9: The compare uses raw bits with no format conversion. For example, hours alarm 0x12 does not match time 0x92 (the 12-hour PM bit set), and 0x59 does not match 0x3B, even though both hold 59 in different formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_done | input | 1 | Update-complete strobe; the compare runs on its rising edge |
| set_hold | input | 1 | High while updates are inhibited by the set control |
| tm_sec | input | W | Current seconds byte |
| tm_min | input | W | Current minutes byte |
| tm_hr | input | W | Current hours byte |
| al_sec | input | W | Seconds alarm byte (MSB set = wildcard) |
| al_min | input | W | Minutes alarm byte (MSB set = wildcard) |
| al_hr | input | W | Hours alarm byte (MSB set = wildcard) |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
There is one register between the strobe and the output. A pulse therefore appears in the cycle right after the clock edge that first sees `upd_done` high, and it drops one edge later. The bench drives inputs on falling edges. It samples `alarm_hit` on the next falling edge to check the pulse, and on the falling edge after that to check that it has dropped. The sweep covers every wildcard mask, with time and alarm bytes computed in the bench. Held strobes, set inhibit and format-sensitive values are added as separate cases, each checked at the same two sample points.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_done,
  input  logic         set_hold,
  input  logic [W-1:0] tm_sec,
  input  logic [W-1:0] tm_min,
  input  logic [W-1:0] tm_hr,
  input  logic [W-1:0] al_sec,
  input  logic [W-1:0] al_min,
  input  logic [W-1:0] al_hr,
  output logic         alarm_hit
);
  localparam int MSB = W - 1;

  logic       upd_q;
  logic [2:0] fld_ok;
  logic       fire;

  assign fld_ok[0] = al_sec[MSB] | (al_sec == tm_sec);
  assign fld_ok[1] = al_min[MSB] | (al_min == tm_min);
  assign fld_ok[2] = al_hr[MSB]  | (al_hr  == tm_hr);
  assign fire      = upd_done & ~upd_q & ~set_hold & (&fld_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q     <= 1'b0;
      alarm_hit <= 1'b0;
    end else begin
      upd_q     <= upd_done;
      alarm_hit <= fire;
    end
  end
endmodule

module alarm_match_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         upd_done,
  input logic         set_hold,
  input logic [W-1:0] tm_sec,
  input logic [W-1:0] tm_min,
  input logic [W-1:0] tm_hr,
  input logic [W-1:0] al_sec,
  input logic [W-1:0] al_min,
  input logic [W-1:0] al_hr,
  input logic         alarm_hit
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!alarm_hit);
    end
  end

  p_only_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> $past(upd_done));

  p_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> !alarm_hit);

  p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && set_hold) |=> !alarm_hit);

  p_sec_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!al_sec[W-1] && (al_sec != tm_sec)) |=> !alarm_hit);

  p_hr_mismatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!al_hr[W-1] && (al_hr != tm_hr)) |=> !alarm_hit);

  p_all_wild_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(upd_done) && !set_hold && al_sec[W-1] && al_min[W-1] && al_hr[W-1])
      |=> alarm_hit);
endmodule

bind alarm_match alarm_match_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .set_hold(set_hold),
  .tm_sec(tm_sec), .tm_min(tm_min), .tm_hr(tm_hr),
  .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr),
  .alarm_hit(alarm_hit)
);

// File: tb/alarm_match_tb.sv
module alarm_match_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_done = 1'b0;
  logic set_hold = 1'b0;
  logic [W-1:0] tm_sec = '0, tm_min = '0, tm_hr = '0;
  logic [W-1:0] al_sec = '0, al_min = '0, al_hr = '0;
  logic alarm_hit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alarm_match #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .set_hold(set_hold),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hr(tm_hr),
    .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr),
    .alarm_hit(alarm_hit)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (alarm_hit !== exp) begin
      errors++;
      $display("FAIL %s: alarm_hit=%b expected %b at %0t", req, alarm_hit, exp, $time);
    end
  endtask

  // Strobe for `len` cycles, check the pulse and the cycles after it.
  task automatic strobe(input int len, input logic exp, input string req);
    @(negedge clk);
    upd_done = 1'b1;
    @(negedge clk);
    check(exp, req);
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      check(1'b0, "R7");
    end
    upd_done = 1'b0;
    @(negedge clk);
    check(1'b0, "R6");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1'b0, "R1");

    // R2/R3/R4/R5: every wildcard mask against computed time bytes
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 24; i++) begin
        logic e;
        logic [2:0] ok;
        @(negedge clk);
        tm_sec = W'((i * 37 + m * 11) & 8'hFF);
        tm_min = W'((i * 53 + m * 7) & 8'hFF);
        tm_hr  = W'((i * 29 + m * 3) & 8'hFF);
        al_sec = m[0] ? W'(8'h80 | (i * 5)) : ((i % 3) == 0 ? tm_sec ^ 8'h01 : tm_sec);
        al_min = m[1] ? W'(8'h80 | (i * 9)) : ((i % 5) == 1 ? tm_min ^ 8'h10 : tm_min);
        al_hr  = m[2] ? W'(8'h80 | (i * 3)) : ((i % 7) == 2 ? tm_hr  ^ 8'h20 : tm_hr);
        ok[0] = al_sec[W-1] || (al_sec == tm_sec);
        ok[1] = al_min[W-1] || (al_min == tm_min);
        ok[2] = al_hr[W-1]  || (al_hr  == tm_hr);
        e = &ok;
        strobe(1, e, m == 7 ? "R5" : (e ? (m != 0 ? "R4" : "R2") : "R3"));
      end
    end

    // R6: matching bytes but no strobe edge -> nothing
    @(negedge clk);
    tm_sec = 8'h15; tm_min = 8'h30; tm_hr = 8'h07;
    al_sec = 8'h15; al_min = 8'h30; al_hr = 8'h07;
    repeat (4) begin
      @(negedge clk);
      check(1'b0, "R6");
    end
    strobe(1, 1'b1, "R2");

    // R7: held strobe yields one pulse
    strobe(5, 1'b1, "R7");

    // R8: set inhibit blocks a matching compare
    set_hold = 1'b1;
    strobe(1, 1'b0, "R8");
    al_sec = 8'hFF; al_min = 8'hFF; al_hr = 8'hFF;
    strobe(1, 1'b0, "R8");
    set_hold = 1'b0;
    strobe(1, 1'b1, "R5");

    // R9: raw bit compare, PM bit counts, BCD vs binary differ
    al_sec = 8'h80; al_min = 8'h80;
    tm_hr = 8'h92; al_hr = 8'h12;
    strobe(1, 1'b0, "R9");
    al_hr = 8'h80;
    strobe(1, 1'b1, "R4");
    tm_hr = 8'h12; al_hr = 8'h12;
    strobe(1, 1'b1, "R9");
    tm_sec = 8'h3B; al_sec = 8'h59;
    strobe(1, 1'b0, "R9");
    tm_sec = 8'h59;
    strobe(1, 1'b1, "R9");

    // R1: reset mid-run clears and stays quiet
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1'b0, "R1");

    finish_run();
  end
endmodule